// File: doc/BRIEF.md
# Linear-Counter Video Timing Engine

This block generates raster timing for a display link from a small register file. A single frame position counter advances by one on every pixel clock and spans the whole frame. A horizontal position counter runs alongside it and restarts at each line end and at each frame wrap. Vertical timing is given as pixel-clock positions on the frame counter rather than as line numbers. Software folds any horizontal sync skew into those positions before writing them.

From the two counters the block derives horizontal sync, vertical sync, data enable, a pixel request for the active window, and a one-clock fetch-start pulse. Inside the display area but outside an optional active sub-window it drives a border colour. Inside the active window it passes the incoming pixel, or an underflow colour when no pixel is valid. Frame and line counters can be read back.

Timing registers are shadowed. A write is visible on readback at once, but it reaches the counters and comparators only at the next frame boundary, or immediately while the engine is stopped. This prevents a torn frame.

Top module: `vtg_engine`

## Requirements
- R1: After reset the engine is stopped, every register reads zero, `hsync`, `vsync`, `de`, `fetch_start` and `pix_req` are 0, and `pix_out` is 0.
- R2: While running, the frame position steps 0,1,…,L−1 and returns to 0, where L is the frame-length register (word 3). The horizontal position steps 0…P−1, where P is bits 31:16 of the line register (word 2), and it also returns to 0 at every frame wrap. The raw horizontal sync is high while the horizontal position is below bits 15:0 of word 2.
- R3: The raw vertical sync is high while the frame position is below the vsync-length register (word 4), counted in pixel clocks.
- R4: The display area is the set of pixels whose horizontal position lies between bits 15:0 (first) and bits 31:16 (last) of word 5 and whose frame position lies between word 6 and word 7, inclusive. Raw data enable equals that area. Outside it `pix_out` is 0.
- R5: Bit 29 of the config register (word 1) narrows the active window horizontally to word 8 (bits 15:0 first, 31:16 last). Bit 30 narrows it vertically to frame positions word 9 through word 10. Display pixels outside the active window carry the border colour (word 11).
- R6: Inside the active window `pix_req` is 1, and `pix_out` is `pix_in` when `pix_valid` is 1, else the underflow colour (word 12).
- R7: Bits 0, 1 and 2 of the polarity register (word 13) invert `hsync`, `vsync` and `de` respectively.
- R8: With config bit 31 set, `fetch_start` is high for exactly the one clock in which the frame position equals word 15.
- R9: Word 16 (frame count) increments at each frame wrap. Word 17 (line count) increments at each horizontal wrap and returns to 0 at a frame wrap. Both change only when word 14 holds 2'b11, and are otherwise frozen. Writes to words 16 and 17 are ignored.
- R10: Clearing bit 0 of word 0 stops the engine. On the next clock every counter is zero, and the outputs sit at their inactive levels after polarity, with `pix_out` 0.
- R11: Words 1–10 and 15 read back the written value at once. While running, they take effect only from the first clock of the next frame. While stopped, they take effect on the next clock. Words 0 and 11–14 take effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| pix_valid | input | 1 | Input pixel is available |
| pix_in | input | COLW | Input pixel colour |
| pix_req | output | 1 | Current pixel lies in the active window |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| fetch_start | output | 1 | One-clock fetch-start pulse |
| pix_out | output | COLW | Output pixel colour |

## Verification
All outputs are combinational functions of the two position counters and the live register set. A corrupted frame or horizontal position therefore shows up on `hsync`, `vsync` or `de` in the same clock it occurs. A shadow copy taken at the wrong moment skews a whole frame of sync edges from the first clock of that frame. A wrong border, underflow or window decision is visible on `pix_out` and `pix_req` at the very pixel involved. Counter errors reach the ports only through readback of words 16 and 17, so those are sampled at several points: after free running, after freezing, and after a stop.

// File: rtl/vtg_engine.sv
module vtg_engine #(
  parameter int COLW = 24,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            pix_valid,
  input  logic [COLW-1:0] pix_in,
  output logic            pix_req,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic            fetch_start,
  output logic [COLW-1:0] pix_out
);

  localparam logic [AW-1:0] A_RUN  = AW'(0);
  localparam logic [AW-1:0] A_CFG  = AW'(1);
  localparam logic [AW-1:0] A_LINE = AW'(2);
  localparam logic [AW-1:0] A_FLEN = AW'(3);
  localparam logic [AW-1:0] A_VLEN = AW'(4);
  localparam logic [AW-1:0] A_DH   = AW'(5);
  localparam logic [AW-1:0] A_DVS  = AW'(6);
  localparam logic [AW-1:0] A_DVE  = AW'(7);
  localparam logic [AW-1:0] A_AH   = AW'(8);
  localparam logic [AW-1:0] A_AVS  = AW'(9);
  localparam logic [AW-1:0] A_AVE  = AW'(10);
  localparam logic [AW-1:0] A_BRD  = AW'(11);
  localparam logic [AW-1:0] A_UFL  = AW'(12);
  localparam logic [AW-1:0] A_POL  = AW'(13);
  localparam logic [AW-1:0] A_CEN  = AW'(14);
  localparam logic [AW-1:0] A_FET  = AW'(15);
  localparam logic [AW-1:0] A_FCNT = AW'(16);
  localparam logic [AW-1:0] A_LCNT = AW'(17);

  logic            run;
  logic [2:0]      cfg_p, cfg_l;
  logic [31:0]     line_p, line_l;
  logic [31:0]     flen_p, flen_l;
  logic [31:0]     vlen_p, vlen_l;
  logic [31:0]     dh_p, dh_l;
  logic [31:0]     dvs_p, dvs_l;
  logic [31:0]     dve_p, dve_l;
  logic [31:0]     ah_p, ah_l;
  logic [31:0]     avs_p, avs_l;
  logic [31:0]     ave_p, ave_l;
  logic [31:0]     fet_p, fet_l;
  logic [COLW-1:0] border, uflow;
  logic [2:0]      pol;
  logic [1:0]      cnt_en;

  logic [31:0]     fpos, frame_cnt, line_cnt;
  logic [15:0]     hpos, hper;
  logic            f_wrap, h_wrap, take;
  logic            hs_raw, vs_raw, disp, h_in, v_in, act;

  assign hper   = line_l[31:16];
  assign f_wrap = (flen_l <= 32'd1) || (fpos >= flen_l - 32'd1);
  assign h_wrap = (hper <= 16'd1) || (hpos >= hper - 16'd1);
  assign take   = !run || f_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cfg_p  <= '0;
      line_p <= '0;
      flen_p <= '0;
      vlen_p <= '0;
      dh_p   <= '0;
      dvs_p  <= '0;
      dve_p  <= '0;
      ah_p   <= '0;
      avs_p  <= '0;
      ave_p  <= '0;
      fet_p  <= '0;
      border <= '0;
      uflow  <= '0;
      pol    <= '0;
      cnt_en <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_RUN:  run    <= reg_wdata[0];
        A_CFG:  cfg_p  <= reg_wdata[31:29];
        A_LINE: line_p <= reg_wdata;
        A_FLEN: flen_p <= reg_wdata;
        A_VLEN: vlen_p <= reg_wdata;
        A_DH:   dh_p   <= reg_wdata;
        A_DVS:  dvs_p  <= reg_wdata;
        A_DVE:  dve_p  <= reg_wdata;
        A_AH:   ah_p   <= reg_wdata;
        A_AVS:  avs_p  <= reg_wdata;
        A_AVE:  ave_p  <= reg_wdata;
        A_BRD:  border <= reg_wdata[COLW-1:0];
        A_UFL:  uflow  <= reg_wdata[COLW-1:0];
        A_POL:  pol    <= reg_wdata[2:0];
        A_CEN:  cnt_en <= reg_wdata[1:0];
        A_FET:  fet_p  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_l  <= '0;
      line_l <= '0;
      flen_l <= '0;
      vlen_l <= '0;
      dh_l   <= '0;
      dvs_l  <= '0;
      dve_l  <= '0;
      ah_l   <= '0;
      avs_l  <= '0;
      ave_l  <= '0;
      fet_l  <= '0;
    end else if (take) begin
      cfg_l  <= cfg_p;
      line_l <= line_p;
      flen_l <= flen_p;
      vlen_l <= vlen_p;
      dh_l   <= dh_p;
      dvs_l  <= dvs_p;
      dve_l  <= dve_p;
      ah_l   <= ah_p;
      avs_l  <= avs_p;
      ave_l  <= ave_p;
      fet_l  <= fet_p;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      fpos      <= '0;
      hpos      <= '0;
      frame_cnt <= '0;
      line_cnt  <= '0;
    end else begin
      if (f_wrap) begin
        fpos <= '0;
        hpos <= '0;
      end else begin
        fpos <= fpos + 32'd1;
        hpos <= h_wrap ? 16'd0 : hpos + 16'd1;
      end
      if (cnt_en == 2'b11) begin
        if (f_wrap) begin
          frame_cnt <= frame_cnt + 32'd1;
          line_cnt  <= '0;
        end else if (h_wrap) begin
          line_cnt <= line_cnt + 32'd1;
        end
      end
    end
  end

  assign hs_raw = run && (hpos < line_l[15:0]);
  assign vs_raw = run && (fpos < vlen_l);
  assign disp   = run && (hpos >= dh_l[15:0]) && (hpos <= dh_l[31:16])
                      && (fpos >= dvs_l) && (fpos <= dve_l);
  assign h_in   = !cfg_l[0] || ((hpos >= ah_l[15:0]) && (hpos <= ah_l[31:16]));
  assign v_in   = !cfg_l[1] || ((fpos >= avs_l) && (fpos <= ave_l));
  assign act    = disp && h_in && v_in;

  assign hsync       = hs_raw ^ pol[0];
  assign vsync       = vs_raw ^ pol[1];
  assign de          = disp ^ pol[2];
  assign pix_req     = act;
  assign fetch_start = run && cfg_l[2] && (fpos == fet_l);
  assign pix_out     = !disp ? '0 : !act ? border : pix_valid ? pix_in : uflow;

  always_comb begin
    case (reg_addr)
      A_RUN:   reg_rdata = {31'd0, run};
      A_CFG:   reg_rdata = {cfg_p, 29'd0};
      A_LINE:  reg_rdata = line_p;
      A_FLEN:  reg_rdata = flen_p;
      A_VLEN:  reg_rdata = vlen_p;
      A_DH:    reg_rdata = dh_p;
      A_DVS:   reg_rdata = dvs_p;
      A_DVE:   reg_rdata = dve_p;
      A_AH:    reg_rdata = ah_p;
      A_AVS:   reg_rdata = avs_p;
      A_AVE:   reg_rdata = ave_p;
      A_BRD:   reg_rdata = 32'(border);
      A_UFL:   reg_rdata = 32'(uflow);
      A_POL:   reg_rdata = {29'd0, pol};
      A_CEN:   reg_rdata = {30'd0, cnt_en};
      A_FET:   reg_rdata = fet_p;
      A_FCNT:  reg_rdata = frame_cnt;
      A_LCNT:  reg_rdata = line_cnt;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/vtg_engine_chk.sv
module vtg_engine_chk #(
  parameter int COLW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic [15:0]     hpos,
  input logic [15:0]     hper,
  input logic [31:0]     fpos,
  input logic [31:0]     flen_l,
  input logic [31:0]     line_l,
  input logic            f_wrap,
  input logic            fetch_start,
  input logic            hsync,
  input logic            vsync,
  input logic            de,
  input logic [2:0]      pol,
  input logic [COLW-1:0] pix_out,
  input logic [31:0]     frame_cnt,
  input logic [31:0]     line_cnt,
  input logic [1:0]      cnt_en
);

  // R10
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (fpos == 32'd0 && hpos == 16'd0 && frame_cnt == 32'd0 && line_cnt == 32'd0));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync == pol[0] && vsync == pol[1] && de == pol[2] && !fetch_start));

  // R2
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && flen_l > 32'd1) |-> fpos < flen_l);

  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hper > 16'd1) |-> hpos < hper);

  // R8
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && !f_wrap) |=> !fetch_start);

  // R11
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !f_wrap) |=> ($stable(line_l) && $stable(flen_l)));

  // R4
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de == pol[2]) |-> pix_out == '0);

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en != 2'b11) |=> ($stable(frame_cnt) && $stable(line_cnt)));

endmodule

bind vtg_engine vtg_engine_chk #(.COLW(COLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .hpos(hpos), .hper(hper),
  .fpos(fpos), .flen_l(flen_l), .line_l(line_l), .f_wrap(f_wrap),
  .fetch_start(fetch_start), .hsync(hsync), .vsync(vsync), .de(de),
  .pol(pol), .pix_out(pix_out), .frame_cnt(frame_cnt),
  .line_cnt(line_cnt), .cnt_en(cnt_en)
);

// File: tb/tb_vtg_engine.sv
module tb_vtg_engine;
  localparam int CLK_PERIOD = 10;
  localparam int COLW = 24;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [AW-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic pix_valid = 1'b0;
  logic [COLW-1:0] pix_in = '0;
  logic pix_req, hsync, vsync, de, fetch_start;
  logic [COLW-1:0] pix_out;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtg_engine #(.COLW(COLW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
    .pix_in(pix_in), .pix_req(pix_req), .hsync(hsync), .vsync(vsync),
    .de(de), .fetch_start(fetch_start), .pix_out(pix_out)
  );

  // behavioural reference: written registers, frame-boundary copies, positions
  logic [31:0] mp [0:15];
  logic [31:0] ml [0:15];
  int unsigned mf, mh, mfc, mlc;

  function automatic bit shadowed(input int a);
    return (a >= 1 && a <= 10) || a == 15;
  endfunction

  function automatic logic [31:0] wmask(input int a);
    case (a)
      0:       return 32'h1;
      1:       return 32'hE000_0000;
      11, 12:  return 32'((64'd1 << COLW) - 1);
      13:      return 32'h7;
      14:      return 32'h3;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input int a);
    if (a < 16) return mp[a];
    if (a == 16) return mfc;
    if (a == 17) return mlc;
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 16; a++) begin mp[a] = '0; ml[a] = '0; end
      mf = 0; mh = 0; mfc = 0; mlc = 0;
    end else begin
      bit run, fw, hw;
      int unsigned per, len;
      run = mp[0][0];
      per = ml[2][31:16];
      len = ml[3];
      fw = (len <= 1) || (mf >= len - 1);
      hw = (per <= 1) || (mh >= per - 1);
      if (!run || fw)
        for (int a = 0; a < 16; a++) if (shadowed(a)) ml[a] = mp[a];
      if (!run) begin
        mf = 0; mh = 0; mfc = 0; mlc = 0;
      end else begin
        if (mp[14][1:0] == 2'b11) begin
          if (fw) begin mfc++; mlc = 0; end
          else if (hw) mlc++;
        end
        if (fw) begin mf = 0; mh = 0; end
        else begin mf++; mh = hw ? 0 : mh + 1; end
      end
      if (reg_we && reg_addr < 16) mp[reg_addr] = reg_wdata & wmask(int'(reg_addr));
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      bit run, hs, vs, disp, act, fe;
      logic [COLW-1:0] px;
      run  = mp[0][0];
      hs   = run && mh < ml[2][15:0];
      vs   = run && mf < ml[4];
      disp = run && mh >= ml[5][15:0] && mh <= ml[5][31:16] && mf >= ml[6] && mf <= ml[7];
      act  = disp && (!ml[1][29] || (mh >= ml[8][15:0] && mh <= ml[8][31:16]))
                  && (!ml[1][30] || (mf >= ml[9] && mf <= ml[10]));
      fe   = run && ml[1][31] && mf == ml[15];
      if (!disp) px = '0;
      else if (!act) px = mp[11][COLW-1:0];
      else if (pix_valid) px = pix_in;
      else px = mp[12][COLW-1:0];
      chk("R2/R7 hsync", 32'(hsync), 32'(hs ^ mp[13][0]));
      chk("R3/R7 vsync", 32'(vsync), 32'(vs ^ mp[13][1]));
      chk("R4/R7 de", 32'(de), 32'(disp ^ mp[13][2]));
      chk("R6 pix_req", 32'(pix_req), 32'(act));
      chk("R8 fetch_start", 32'(fetch_start), 32'(fe));
      chk("R5/R6 pix_out", 32'(pix_out), 32'(px));
    end
  end

  initial begin : pix_gen
    int unsigned cyc = 0;
    forever begin
      @(posedge clk); #2;
      cyc++;
      pix_valid = (cyc % 7) != 3;
      pix_in = COLW'(cyc * 32'h9E37);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    reg_addr = AW'(a);
    @(negedge clk); #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic rd_model(input int a, input string tag);
    @(posedge clk); #2;
    reg_addr = AW'(a);
    @(negedge clk); #1;
    chk(tag, reg_rdata, model_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  initial begin : stim
    logic [31:0] held;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 hsync", 32'(hsync), 0);
    chk("R1 vsync", 32'(vsync), 0);
    chk("R1 de", 32'(de), 0);
    chk("R1 pix_out", 32'(pix_out), 0);
    chk("R1 fetch", 32'(fetch_start), 0);
    chk("R1 rdata", reg_rdata, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    chk_on = 1'b1;
    rd(16, 0, "R1 frame count");
    rd(2, 0, "R1 line reg");

    // 10-pixel lines, 6 lines, sync 2 px, 1 vsync line, display rows 2..4
    wr(2, {16'd10, 16'd2});
    wr(3, 32'd60);
    wr(4, 32'd10);
    wr(5, {16'd8, 16'd4});
    wr(6, 32'd20);
    wr(7, 32'd49);
    wr(8, {16'd7, 16'd5});
    wr(9, 32'd30);
    wr(10, 32'd39);
    wr(11, 32'h0011_2233);
    wr(12, 32'h00AB_CDEF);
    wr(15, 32'd5);
    wr(14, 32'd3);
    wr(0, 32'd1);
    idle(183);
    rd_model(16, "R9 frame count running");
    rd_model(17, "R9 line count running");

    wr(1, 32'hE000_0000);
    rd(1, 32'hE000_0000, "R11 config readback");
    idle(200);

    wr(13, 32'd7);
    idle(130);
    wr(13, 32'd2);
    idle(37);

    // mid-frame retiming: 12-pixel lines, skew 3 folded into vertical positions
    wr(2, {16'd12, 16'd3});
    rd(2, {16'd12, 16'd3}, "R11 line readback immediate");
    wr(5, {16'd10, 16'd5});
    wr(3, 32'd72);
    wr(4, 32'd12);
    wr(6, 32'd27);
    wr(7, 32'd62);
    wr(8, {16'd9, 16'd6});
    wr(9, 32'd36);
    wr(10, 32'd47);
    wr(15, 32'd8);
    idle(300);
    rd_model(17, "R9 line count after retime");

    wr(14, 32'd1);
    rd_model(16, "R9 frame count at freeze");
    held = reg_rdata;
    idle(150);
    rd(16, held, "R9 frame count frozen");
    wr(16, 32'h55);
    rd(16, held, "R9 write to count ignored");
    wr(14, 32'd3);
    idle(100);
    rd_model(16, "R9 frame count resumed");

    wr(0, 32'd0);
    idle(2);
    rd(16, 0, "R10 frame count cleared");
    rd(17, 0, "R10 line count cleared");
    wr(1, 32'h2000_0000);
    idle(20);
    wr(0, 32'd1);
    idle(220);
    rd_model(17, "R9 line count after restart");
    finish_run();
  end
endmodule